// File: doc/BRIEF.md
# Single-Cell Battery Protection Sampling Controller

This block is the digital decision core of a protector for one lithium cell. Analog comparators outside the block report the cell state as logic levels: above the maximum voltage, above the maximum plus a 100 mV margin, more than 20 mV below the maximum, below the minimum, charge overcurrent and discharge overcurrent. Two further inputs report whether a charger or a load is attached. From these the block decides whether the series MOSFET pair conducts, whether the cell bypass switch is closed, and whether the full and sleep flags are raised.

Voltage is checked on discrete samples taken from a quarter-second timebase. The timebase is a prescaler of `QTR_CYCLES` clocks. While the cell is healthy, a sample falls on every fourth quarter, once a second. After the first sample above the maximum, the following samples come every quarter until the fault is confirmed or a sample fails to confirm it. Overcurrent does not use the sampler. Each direction has its own cycle counter and delay.

The enable input takes the pack out of sleep. While enable is low, every fault, counter and timing phase is held cleared and the gate is off. A rising edge therefore restarts the sample history and turns the gate on again.

Top module: `cell_guard`

## Requirements
- R1: While `en` is low, `sleep` is 1 and `gate_on`, `bypass_on` and `full` are 0, including when a bypass was active. After reset, with `en` low, the outputs show this same state.
- R2: Counting from the first rising clock edge with `en` high as edge 1, quarter ticks fall on edges k·QTR_CYCLES. A normal sample falls on every fourth quarter tick, so the first sample is on edge 4·QTR_CYCLES.
- R3: Four consecutive samples with `v_hi`=1 turn the gate off. The three confirming samples come one quarter apart, so with `v_hi` held from enable the gate drops right after edge 7·QTR_CYCLES.
- R4: A sample with both `v_hi` and `v_hi_margin` at 1 turns the gate off on that sample.
- R5: A sample with `v_hi`=0 clears the above-maximum count, and the next sample falls four quarters later.
- R6: An overcharge trip sets `bypass_on` and `full` (always equal) on the same edge. Both clear on the first edge that sees `v_hi`=0.
- R7: After an overcharge trip, the gate turns back on at the first edge that sees `load_det`=1 or `v_hyst_lo`=1.
- R8: Four consecutive samples with `v_lo`=1 and `v_hi`=0 turn the gate off. With `v_lo` held from enable this happens right after edge 16·QTR_CYCLES.
- R9: After an undervoltage trip, the gate turns back on at the first edge that sees `chg_det`=1.
- R10: `oc_chg` high on OCC_DLY+1 consecutive edges turns the gate off. High on only OCC_DLY edges does not. A low edge restarts the count.
- R11: `oc_dsg` high on OCD_DLY+1 consecutive edges turns the gate off. High on only OCD_DLY edges does not.
- R12: An overcurrent trip is not cleared by `chg_det`, `load_det` or `v_hyst_lo`. Only a low period on `en` followed by a rise re-arms the gate.
- R13: A rising edge on `en` turns the gate on after the first edge and discards earlier above-maximum samples. A persisting overcharge then needs the full 7·QTR_CYCLES again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Pack enable; low means sleep |
| v_hi | input | 1 | Cell above maximum voltage |
| v_hi_margin | input | 1 | Cell above maximum plus margin |
| v_hyst_lo | input | 1 | Cell below maximum minus hysteresis |
| v_lo | input | 1 | Cell below minimum voltage |
| oc_chg | input | 1 | Charge current above its limit |
| oc_dsg | input | 1 | Discharge current above its limit |
| chg_det | input | 1 | Charger attached |
| load_det | input | 1 | Load attached |
| gate_on | output | 1 | MOSFET pair conducts |
| bypass_on | output | 1 | Cell bypass switch closed |
| full | output | 1 | Overcharge flag |
| sleep | output | 1 | Sleep state |

## Verification
Inputs change on falling edges, and the bench counts rising edges from the first one with `en` high. Voltage results are due right after edge k·QTR_CYCLES for the sample index k: 4 for a margin trip, 7 for a confirmed overcharge, 16 for undervoltage. An overcurrent trip is due right after the (DLY+1)th consecutive high edge, and recoveries and releases are due right after the next edge. Each timed check samples one falling edge before the due edge and one after it. Any early or late change is therefore reported.

// File: rtl/cell_guard.sv
module cell_guard #(
  parameter int QTR_CYCLES = 31_250_000,
  parameter int SLOW_QTRS  = 4,
  parameter int OV_CONFIRM = 4,
  parameter int UV_CONFIRM = 4,
  parameter int OCC_DLY    = 1_000_000,
  parameter int OCD_DLY    = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic v_hi,
  input  logic v_hi_margin,
  input  logic v_hyst_lo,
  input  logic v_lo,
  input  logic oc_chg,
  input  logic oc_dsg,
  input  logic chg_det,
  input  logic load_det,
  output logic gate_on,
  output logic bypass_on,
  output logic full,
  output logic sleep
);

  localparam int QW = $clog2(QTR_CYCLES);
  localparam int PW = $clog2(SLOW_QTRS);
  localparam int OW = $clog2(OV_CONFIRM);
  localparam int UW = $clog2(UV_CONFIRM);
  localparam int CW = $clog2(OCC_DLY + 1);
  localparam int DW = $clog2(OCD_DLY + 1);
  localparam logic [QW-1:0] Q_LAST  = QW'(QTR_CYCLES - 1);
  localparam logic [PW-1:0] P_LAST  = PW'(SLOW_QTRS - 1);
  localparam logic [OW-1:0] OV_LAST = OW'(OV_CONFIRM - 1);
  localparam logic [UW-1:0] UV_LAST = UW'(UV_CONFIRM - 1);
  localparam logic [CW-1:0] OCC_MAX = CW'(OCC_DLY);
  localparam logic [DW-1:0] OCD_MAX = DW'(OCD_DLY);

  logic [QW-1:0] pre;
  logic [PW-1:0] phase;
  logic [OW-1:0] ov_cnt;
  logic [UW-1:0] uv_cnt;
  logic [CW-1:0] occ_cnt;
  logic [DW-1:0] ocd_cnt;
  logic ovc_trip, od_trip, occ_trip, ocd_trip, full_r;
  logic q_tick, smp, ov_fire, uv_fire, uv_qual;

  assign q_tick  = (pre == Q_LAST);
  assign smp     = q_tick & ((ov_cnt != '0) | (phase == P_LAST));
  assign ov_fire = smp & v_hi & (v_hi_margin | (ov_cnt == OV_LAST));
  assign uv_qual = v_lo & ~v_hi;
  assign uv_fire = smp & uv_qual & (uv_cnt == UV_LAST);

  assign gate_on   = en & ~(ovc_trip | od_trip | occ_trip | ocd_trip);
  assign bypass_on = en & full_r;
  assign full      = en & full_r;
  assign sleep     = ~en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; phase <= '0; ov_cnt <= '0; uv_cnt <= '0;
    end else if (!en) begin
      pre <= '0; phase <= '0; ov_cnt <= '0; uv_cnt <= '0;
    end else begin
      pre <= q_tick ? '0 : pre + 1'b1;
      if (smp) begin
        phase  <= '0;
        ov_cnt <= (v_hi && !ov_fire) ? ov_cnt + 1'b1 : '0;
        uv_cnt <= (uv_qual && !uv_fire) ? uv_cnt + 1'b1 : '0;
      end else if (q_tick) begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovc_trip <= 1'b0; od_trip <= 1'b0; full_r <= 1'b0;
    end else if (!en) begin
      ovc_trip <= 1'b0; od_trip <= 1'b0; full_r <= 1'b0;
    end else begin
      if (ovc_trip) begin
        if (load_det || v_hyst_lo) ovc_trip <= 1'b0;
      end else if (ov_fire) begin
        ovc_trip <= 1'b1;
      end
      if (od_trip) begin
        if (chg_det) od_trip <= 1'b0;
      end else if (uv_fire) begin
        od_trip <= 1'b1;
      end
      full_r <= ov_fire | (full_r & v_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_cnt <= '0; ocd_cnt <= '0; occ_trip <= 1'b0; ocd_trip <= 1'b0;
    end else if (!en) begin
      occ_cnt <= '0; ocd_cnt <= '0; occ_trip <= 1'b0; ocd_trip <= 1'b0;
    end else begin
      if (!oc_chg) occ_cnt <= '0;
      else if (occ_cnt != OCC_MAX) occ_cnt <= occ_cnt + 1'b1;
      else occ_trip <= 1'b1;
      if (!oc_dsg) ocd_cnt <= '0;
      else if (ocd_cnt != OCD_MAX) ocd_cnt <= ocd_cnt + 1'b1;
      else ocd_trip <= 1'b1;
    end
  end

  p_sleep_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !full_r && !ovc_trip && !od_trip && !occ_trip && !ocd_trip);

  p_ovc_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovc_trip) |-> $past(v_hi));

  p_full_with_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_r) |-> ovc_trip);

  p_full_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_r && !v_hi |=> !full_r);

  p_ovc_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_trip && (load_det || v_hyst_lo) |=> !ovc_trip);

  p_od_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_trip) |-> $past(v_lo));

  p_od_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    od_trip && chg_det |=> !od_trip);

  p_occ_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(occ_trip) |-> $past(oc_chg));

  p_ocd_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocd_trip) |-> $past(oc_dsg));

  p_oc_latched_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en && (occ_trip || ocd_trip) |=> occ_trip || ocd_trip);

endmodule

// File: tb/cell_guard_test.sv
`timescale 1ns/1ps
module cell_guard_test;
  localparam int Q = 4;
  localparam int OCC = 5;
  localparam int OCD = 9;

  logic clk = 1'b0;
  logic rst_n, en, v_hi, v_hi_margin, v_hyst_lo, v_lo, oc_chg, oc_dsg, chg_det, load_det;
  logic gate_on, bypass_on, full, sleep;
  int total = 0;
  int fails = 0;
  int seed_init;

  always #4 clk = ~clk;

  cell_guard #(.QTR_CYCLES(Q), .SLOW_QTRS(4), .OV_CONFIRM(4), .UV_CONFIRM(4),
               .OCC_DLY(OCC), .OCD_DLY(OCD)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .v_hi(v_hi), .v_hi_margin(v_hi_margin),
    .v_hyst_lo(v_hyst_lo), .v_lo(v_lo), .oc_chg(oc_chg), .oc_dsg(oc_dsg),
    .chg_det(chg_det), .load_det(load_det), .gate_on(gate_on),
    .bypass_on(bypass_on), .full(full), .sleep(sleep));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    v_hi = 0; v_hi_margin = 0; v_hyst_lo = 0; v_lo = 0;
    oc_chg = 0; oc_dsg = 0; chg_det = 0; load_det = 0;
  endtask

  task automatic restart();
    en = 0;
    tick(2);
    en = 1;
  endtask

  function automatic logic oc_gate_exp(input int len, input int dly);
    return !(len > dly);
  endfunction

  function automatic logic ov_gate_exp(input int n, input bit mg);
    return !(mg || n >= 4);
  endfunction

  initial begin
    seed_init = $urandom(32'h5eed);
    rst_n = 0; en = 0; quiet();
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 reset gate", gate_on, 0);
    chk("R1 reset sleep", sleep, 1);
    chk("R1 reset bypass", bypass_on, 0);
    chk("R1 reset full", full, 0);

    // R3 / R6 / R7 via load
    restart(); v_hi = 1;
    tick(7*Q - 1); chk("R3 gate before 4th sample", gate_on, 1);
    tick(1);       chk("R3 gate after 4th sample", gate_on, 0);
    chk("R6 full set", full, 1);
    chk("R6 bypass set", bypass_on, 1);
    load_det = 1;
    tick(1); chk("R7 load recovery", gate_on, 1);
    chk("R6 bypass held while above max", bypass_on, 1);
    v_hi = 0; load_det = 0;
    tick(1); chk("R6 bypass released", bypass_on, 0);
    chk("R6 full released", full, 0);

    // R7 via hysteresis
    quiet(); restart(); v_hi = 1;
    tick(7*Q); chk("R7 tripped", gate_on, 0);
    v_hi = 0; v_hyst_lo = 1;
    tick(1); chk("R7 hysteresis recovery", gate_on, 1);

    // R4 / R2 margin trip on first sample, then R1 with bypass active
    quiet(); restart(); v_hi = 1; v_hi_margin = 1;
    tick(4*Q - 1); chk("R2 no sample before 1s grid", gate_on, 1);
    tick(1);       chk("R4 margin trip on first sample", gate_on, 0);
    chk("R4 full on margin trip", full, 1);
    en = 0;
    tick(1); chk("R1 sleep flag", sleep, 1);
    chk("R1 bypass off in sleep", bypass_on, 0);
    chk("R1 full off in sleep", full, 0);
    chk("R1 gate off in sleep", gate_on, 0);

    // R5 broken sequence returns to slow sampling
    quiet(); restart(); v_hi = 1;
    tick(5*Q); v_hi = 0;
    tick(Q);   v_hi = 1;
    tick(7*Q - 1); chk("R5 gate before re-confirmed trip", gate_on, 1);
    tick(1);       chk("R5 trip after slow restart", gate_on, 0);

    // R8 / R9
    quiet(); restart(); v_lo = 1;
    tick(16*Q - 1); chk("R8 gate before 4th slow sample", gate_on, 1);
    tick(1);        chk("R8 undervoltage trip", gate_on, 0);
    chg_det = 1;
    tick(1); chk("R9 charger recovery", gate_on, 1);

    // R13 enable edge clears history
    quiet(); restart(); v_hi = 1;
    tick(6*Q + 2);
    en = 0;
    tick(2); chk("R1 sleep during cycle", gate_on, 0);
    en = 1;
    tick(1); chk("R13 gate re-armed", gate_on, 1);
    tick(7*Q - 2); chk("R13 history cleared", gate_on, 1);
    tick(1); chk("R13 trip after full delay", gate_on, 0);

    // R10 / R12
    quiet(); restart(); oc_chg = 1;
    tick(OCC); oc_chg = 0;
    tick(1); oc_chg = 1;
    tick(OCC); oc_chg = 0;
    tick(2); chk("R10 no trip at delay / counter restart", gate_on, 1);
    oc_chg = 1;
    tick(OCC); chk("R10 gate before delay exceeded", gate_on, 1);
    tick(1);   chk("R10 charge overcurrent trip", gate_on, 0);
    oc_chg = 0; chg_det = 1; load_det = 1; v_hyst_lo = 1;
    tick(10); chk("R12 latched despite other recoveries", gate_on, 0);
    quiet(); restart();
    tick(1); chk("R12 enable cycle re-arms", gate_on, 1);

    // R11
    quiet(); restart(); oc_dsg = 1;
    tick(OCD); chk("R11 gate at delay", gate_on, 1);
    tick(1);   chk("R11 discharge overcurrent trip", gate_on, 0);
    quiet();

    // random overcurrent pulses (R10, R11)
    for (int i = 0; i < 24; i++) begin
      int len; bit dsg; int dly;
      dsg = 1'($urandom % 2);
      dly = dsg ? OCD : OCC;
      len = 1 + int'($urandom % (dly + 3));
      quiet(); restart();
      if (dsg) oc_dsg = 1; else oc_chg = 1;
      tick(len);
      quiet();
      tick(2);
      chk(dsg ? "R11 random pulse" : "R10 random pulse", gate_on, oc_gate_exp(len, dly));
    end

    // random overcharge sample runs (R3, R4, R5)
    for (int i = 0; i < 16; i++) begin
      int n; bit mg;
      n = 1 + int'($urandom % 4);
      mg = ($urandom % 4) == 0;
      quiet(); restart();
      v_hi = 1; v_hi_margin = mg;
      tick(4*Q + (n - 1)*Q);
      quiet();
      tick(14);
      chk("R3 R4 R5 random sample run", gate_on, ov_gate_exp(n, mg));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule